// File: doc/BRIEF.md
# Microcontroller Internal Data Memory Unit

This block is the on-chip data store of a small 8-bit microcontroller core. It holds 256 bytes of RAM and resolves every core access to a location. The location depends on the access kind: direct byte, indirect byte, bank register, single bit, stack push or stack pop. The same upper-half address reaches one of two places. A direct access goes to the special-function-register window. An indirect access goes to the upper 128 bytes of RAM.

The core drives one access per cycle through the access port. The result comes back on `rd_data` and `rd_bit` after the next rising clock edge. Peripheral registers sit outside the block. They are reached through a side port that carries the address, the write data and the read and write strobes. The peripheral returns read data and an implemented flag in the same cycle. The block keeps the stack pointer itself at direct address 81h. It applies register-bank selection from a 2-bit bank input.

Top module: `dmem_unit`

## Requirements
- R1: While reset is held, and after it is released, `rd_data` and `rd_bit` are 0. The stack pointer reads back as 07h.
- R2: Indirect accesses (kind 1) reach RAM bytes 00h–FFh. Direct accesses (kind 0) to 00h–7Fh reach the same RAM bytes.
- R3: A direct access to 80h–FFh (other than 81h) goes to the side port and leaves upper RAM unchanged.
- R4: A register access (kind 2) to register n (`acc_addr[2:0]`) addresses RAM byte `bank_sel*8 + n`.
- R5: A push (kind 4) first increments the stack pointer, then writes `acc_wdata` at the new value. After reset the first push lands at 08h.
- R6: A pop (kind 5) returns the RAM byte at the stack pointer, then decrements it. The pointer wraps modulo 256 and reaches upper RAM.
- R7: A bit access (kind 3) with bit address b < 80h selects RAM byte 20h + (b>>3), bit b&7. Those bytes stay readable as whole bytes.
- R8: A bit write (`acc_we`=1, value `acc_bit_wr`) changes only the addressed bit. The other seven bits of the byte keep their values.
- R9: A bit access with b ≥ 80h selects side-port byte b&F8h, bit b&7. A write is a read-modify-write through the side port.
- R10: When the peripheral reports the address unimplemented (`sfr_hit`=0), `sfr_we` stays low and a read returns 00h (bit 0).
- R11: Direct address 81h reads and writes the stack pointer and never asserts `sfr_re` or `sfr_we`.
- R12: Each access with `acc_valid`=1 and kind 0–5 loads `rd_data` with the addressed byte's value before the access. Bit accesses also load `rd_bit`. Idle cycles and kinds 6–7 leave both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access strobe for this cycle |
| acc_kind | input | 3 | 0 direct, 1 indirect, 2 register, 3 bit, 4 push, 5 pop |
| acc_addr | input | 8 | Byte address, register number or bit address |
| acc_wdata | input | 8 | Byte write data, also the push data |
| acc_we | input | 1 | Write request for kinds 0–3 |
| acc_bit_wr | input | 1 | Bit value for bit writes |
| bank_sel | input | 2 | Selected register bank |
| rd_data | output | 8 | Byte value of the last access, before its write |
| rd_bit | output | 1 | Bit value of the last bit access |
| sfr_addr | output | 8 | Peripheral register address |
| sfr_wdata | output | 8 | Peripheral write data |
| sfr_we | output | 1 | Peripheral write strobe |
| sfr_re | output | 1 | Peripheral read strobe |
| sfr_rdata | input | 8 | Peripheral read data, same cycle |
| sfr_hit | input | 1 | Peripheral address is implemented, same cycle |

## Verification
The side-port strobes are combinational. The bench checks `sfr_we` one time unit after driving an access, in the same cycle. `rd_data` and `rd_bit` pass through one register. The bench samples them one time unit after the rising edge that closes the access, and compares them with a behavioural model on every clock, including idle ones. Writes are confirmed by later reads of the same location through each access kind, so each result is compared exactly one edge after its stimulus.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam logic [2:0] KIND_DIR  = 3'd0;
  localparam logic [2:0] KIND_IND  = 3'd1;
  localparam logic [2:0] KIND_REG  = 3'd2;
  localparam logic [2:0] KIND_BIT  = 3'd3;
  localparam logic [2:0] KIND_PUSH = 3'd4;
  localparam logic [2:0] KIND_POP  = 3'd5;

  // decoded destination of one access
  typedef struct packed {
    logic act;     // a valid, recognised access
    logic to_ram;
    logic to_sfr;
    logic to_sp;
    logic is_bit;
    logic wr;
    logic sp_inc;
    logic sp_dec;
  } route_t;
endpackage

// File: rtl/dmem_addr_map.sv
module dmem_addr_map
  import dmem_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int BANK_W   = 2,
  parameter int RN_W     = 3,
  parameter int BIT_BASE = 32,
  parameter int SP_ADDR  = 129
) (
  input  logic              valid,
  input  logic [2:0]        kind,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [BANK_W-1:0] bank,
  input  logic [AW-1:0]     sp_q,
  output route_t            rt,
  output logic [AW-1:0]     tgt,
  output logic [$clog2(DW)-1:0] bit_idx
);
  localparam int BI_W  = $clog2(DW);
  localparam int PAD_W = AW - BANK_W - RN_W;

  logic lower;
  assign lower   = ~addr[AW-1];
  assign bit_idx = addr[BI_W-1:0];

  always_comb begin
    rt  = '0;
    tgt = addr;
    unique case (kind)
      KIND_DIR: begin
        rt.act = valid;
        rt.wr  = we;
        if (lower)                       rt.to_ram = 1'b1;
        else if (addr == AW'(SP_ADDR))   rt.to_sp  = 1'b1;
        else                             rt.to_sfr = 1'b1;
      end
      KIND_IND: begin
        rt.act    = valid;
        rt.wr     = we;
        rt.to_ram = 1'b1;
      end
      KIND_REG: begin
        rt.act    = valid;
        rt.wr     = we;
        rt.to_ram = 1'b1;
        tgt       = {{PAD_W{1'b0}}, bank, addr[RN_W-1:0]};
      end
      KIND_BIT: begin
        rt.act    = valid;
        rt.wr     = we;
        rt.is_bit = 1'b1;
        if (lower) begin
          rt.to_ram = 1'b1;
          tgt       = AW'(BIT_BASE) + (addr >> BI_W);
        end else begin
          rt.to_sfr = 1'b1;
          tgt       = {addr[AW-1:BI_W], {BI_W{1'b0}}};
        end
      end
      KIND_PUSH: begin
        rt.act    = valid;
        rt.wr     = 1'b1;
        rt.to_ram = 1'b1;
        rt.sp_inc = 1'b1;
        tgt       = sp_q + AW'(1);
      end
      KIND_POP: begin
        rt.act    = valid;
        rt.to_ram = 1'b1;
        rt.sp_dec = 1'b1;
        tgt       = sp_q;
      end
      default: rt = '0;
    endcase
  end
endmodule

// File: rtl/dmem_stack_ptr.sv
module dmem_stack_ptr #(
  parameter int AW       = 8,
  parameter int SP_RESET = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  output logic [AW-1:0] sp_q
);
  logic [AW-1:0] sp_d;
  logic          sp_en;

  assign sp_en = ld | inc | dec;

  always_comb begin
    sp_d = sp_q;
    if (ld)       sp_d = ld_val;
    else if (inc) sp_d = sp_q + AW'(1);
    else if (dec) sp_d = sp_q - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= AW'(SP_RESET);
    else if (sp_en) sp_q <= sp_d;
  end

  p_sp_onecmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ld, inc, dec}) <= 1);
endmodule

// File: rtl/dmem_ram_array.sv
module dmem_ram_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  // storage carries no reset; contents are defined by writes
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/dmem_unit.sv
module dmem_unit
  import dmem_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int BANK_W   = 2,
  parameter int RN_W     = 3,
  parameter int BIT_BASE = 32,
  parameter int SP_ADDR  = 129,
  parameter int SP_RESET = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [2:0]        acc_kind,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  input  logic              acc_we,
  input  logic              acc_bit_wr,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [DW-1:0]     rd_data,
  output logic              rd_bit,
  output logic [AW-1:0]     sfr_addr,
  output logic [DW-1:0]     sfr_wdata,
  output logic              sfr_we,
  output logic              sfr_re,
  input  logic [DW-1:0]     sfr_rdata,
  input  logic              sfr_hit
);
  localparam int BI_W = $clog2(DW);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  route_t          rt;
  logic [AW-1:0]   tgt;
  logic [BI_W-1:0] bit_idx;
  logic [AW-1:0]   sp_q;
  logic [DW-1:0]   ram_rdata;
  logic [DW-1:0]   ram_wdata;
  logic            ram_we;
  logic [DW-1:0]   old_byte;
  logic [DW-1:0]   new_byte;

  dmem_addr_map #(
    .AW(AW), .DW(DW), .BANK_W(BANK_W), .RN_W(RN_W),
    .BIT_BASE(BIT_BASE), .SP_ADDR(SP_ADDR)
  ) u_map (
    .valid  (acc_valid),
    .kind   (acc_kind),
    .addr   (acc_addr),
    .we     (acc_we),
    .bank   (bank_sel),
    .sp_q   (sp_q),
    .rt     (rt),
    .tgt    (tgt),
    .bit_idx(bit_idx)
  );

  dmem_stack_ptr #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (rt.act & rt.sp_inc),
    .dec   (rt.act & rt.sp_dec),
    .ld    (rt.act & rt.to_sp & rt.wr),
    .ld_val(acc_wdata),
    .sp_q  (sp_q)
  );

  dmem_ram_array #(.AW(AW), .DW(DW)) u_ram (
    .clk  (clk),
    .addr (tgt),
    .we   (ram_we),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  // value of the addressed byte before this access
  always_comb begin
    old_byte = '0;
    if (rt.to_ram)                old_byte = ram_rdata;
    else if (rt.to_sp)            old_byte = sp_q;
    else if (rt.to_sfr && sfr_hit) old_byte = sfr_rdata;
  end

  // merged write value: a whole byte or one replaced bit
  always_comb begin
    new_byte = acc_wdata;
    if (rt.is_bit) begin
      new_byte          = old_byte;
      new_byte[bit_idx] = acc_bit_wr;
    end
  end

  assign ram_we    = rt.act & rt.to_ram & rt.wr;
  assign ram_wdata = new_byte;
  assign sfr_addr  = tgt;
  assign sfr_wdata = new_byte;
  assign sfr_re    = rt.act & rt.to_sfr;
  assign sfr_we    = rt.act & rt.to_sfr & rt.wr & sfr_hit;

  // result registers
  logic [DW-1:0] rd_data_d;
  logic          rd_bit_d;
  logic          rd_en;
  logic          bit_en;

  assign rd_en  = rt.act;
  assign bit_en = rt.act & rt.is_bit;

  always_comb begin
    rd_data_d = rd_data;
    rd_bit_d  = rd_bit;
    if (rd_en)  rd_data_d = old_byte;
    if (bit_en) rd_bit_d  = old_byte[bit_idx];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data <= '0;
      rd_bit  <= 1'b0;
    end else begin
      if (rd_en)  rd_data <= rd_data_d;
      if (bit_en) rd_bit  <= rd_bit_d;
    end
  end

  // checks
  p_sfr_upper_only_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sfr_re |-> (acc_addr[AW-1] && (acc_kind == KIND_DIR || acc_kind == KIND_BIT)));

  p_unimpl_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sfr_hit |-> !sfr_we);

  p_sp_local_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_kind == KIND_DIR && acc_addr == AW'(SP_ADDR)) |-> (!sfr_re && !sfr_we));

  p_push_preinc_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_kind == KIND_PUSH) |=> (sp_q == $past(sp_q) + AW'(1)));

  p_pop_postdec_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && acc_kind == KIND_POP) |=> (sp_q == $past(sp_q) - AW'(1)));

  p_bit_single_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ram_we && acc_kind == KIND_BIT) |-> ($countones(ram_wdata ^ ram_rdata) <= 1));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid |=> ($stable(rd_data) && $stable(rd_bit)));
endmodule

// File: tb/dmem_unit_bench.sv
module dmem_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [2:0] acc_kind = 3'd0;
  logic [7:0] acc_addr = 8'h00;
  logic [7:0] acc_wdata = 8'h00;
  logic       acc_we = 1'b0;
  logic       acc_bit_wr = 1'b0;
  logic [1:0] bank_sel = 2'd0;
  logic [7:0] rd_data;
  logic       rd_bit;
  logic [7:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic       sfr_we;
  logic       sfr_re;
  logic [7:0] sfr_rdata;
  logic       sfr_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_unit u_dmem_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_we(acc_we),
    .acc_bit_wr(acc_bit_wr), .bank_sel(bank_sel), .rd_data(rd_data),
    .rd_bit(rd_bit), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_re(sfr_re), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit)
  );

  // peripheral stand-in
  logic [7:0] pdev [256];
  function automatic bit impl(input logic [7:0] a);
    return (a == 8'h80 || a == 8'h88 || a == 8'h90 || a == 8'h98 ||
            a == 8'hA0 || a == 8'hB0 || a == 8'hE0 || a == 8'hF0);
  endfunction
  assign sfr_hit   = impl(sfr_addr);
  assign sfr_rdata = pdev[sfr_addr];
  always @(posedge clk) if (sfr_we) pdev[sfr_addr] <= sfr_wdata;

  // reference model
  logic [7:0] mram [256];
  logic [7:0] msfr [256];
  logic [7:0] msp;
  logic [7:0] exp_data;
  logic       exp_bit;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input int k, input logic [7:0] a,
                      input logic [7:0] wd, input logic we, input logic bi,
                      input logic [1:0] bk, input logic v);
    logic [7:0] ba;
    logic [7:0] old;
    logic       sw;
    @(negedge clk);
    acc_valid = v; acc_kind = 3'(k); acc_addr = a; acc_wdata = wd;
    acc_we = we; acc_bit_wr = bi; bank_sel = bk;
    sw = 1'b0;
    if (v) begin
      case (k)
        0: begin
          if (a < 8'h80) begin
            exp_data = mram[a]; if (we) mram[a] = wd;
          end else if (a == 8'h81) begin
            exp_data = msp; if (we) msp = wd;
          end else begin
            exp_data = impl(a) ? msfr[a] : 8'h00;
            if (we && impl(a)) begin msfr[a] = wd; sw = 1'b1; end
          end
        end
        1: begin exp_data = mram[a]; if (we) mram[a] = wd; end
        2: begin
          ba = {3'b000, bk, a[2:0]};
          exp_data = mram[ba]; if (we) mram[ba] = wd;
        end
        3: begin
          if (a < 8'h80) begin
            ba = 8'h20 + (a >> 3);
            old = mram[ba];
            exp_data = old; exp_bit = old[a[2:0]];
            if (we) begin old[a[2:0]] = bi; mram[ba] = old; end
          end else begin
            ba = a & 8'hF8;
            old = impl(ba) ? msfr[ba] : 8'h00;
            exp_data = old; exp_bit = old[a[2:0]];
            if (we && impl(ba)) begin old[a[2:0]] = bi; msfr[ba] = old; sw = 1'b1; end
          end
        end
        4: begin msp = msp + 8'd1; exp_data = mram[msp]; mram[msp] = wd; end
        5: begin exp_data = mram[msp]; msp = msp - 8'd1; end
        default: ;
      endcase
    end
    #1;
    chk({tag, " sfr_we"}, {7'd0, sfr_we}, {7'd0, sw});
    @(posedge clk);
    #1;
    chk({tag, " rd_data"}, rd_data, exp_data);
    chk({tag, " rd_bit"}, {7'd0, rd_bit}, {7'd0, exp_bit});
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      pdev[i] = 8'(i ^ 8'h5A);
      msfr[i] = 8'(i ^ 8'h5A);
      mram[i] = 8'h00;
    end
    msp = 8'h07; exp_data = 8'h00; exp_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd_data in reset", rd_data, 8'h00);
    chk("R1 rd_bit in reset", {7'd0, rd_bit}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) idle("R1 after release");
    step("R1 R11 sp reset read", 0, 8'h81, 8'h00, 0, 0, 0, 1);
    // fill all RAM indirectly
    for (int i = 0; i < 256; i++)
      step("R2 fill", 1, 8'(i), 8'(i * 7 + 3), 1, 0, 0, 1);
    step("R2 direct low", 0, 8'h05, 8'h00, 0, 0, 0, 1);
    step("R2 direct low", 0, 8'h7F, 8'h00, 0, 0, 0, 1);
    step("R2 indirect high", 1, 8'hC4, 8'h00, 0, 0, 0, 1);
    step("R2 direct write low", 0, 8'h44, 8'hE1, 1, 0, 0, 1);
    step("R2 indirect read low", 1, 8'h44, 8'h00, 0, 0, 0, 1);
    // SFR window
    step("R3 direct sfr write", 0, 8'hA0, 8'h3C, 1, 0, 0, 1);
    step("R3 upper ram intact", 1, 8'hA0, 8'h00, 0, 0, 0, 1);
    step("R3 direct sfr read", 0, 8'hA0, 8'h00, 0, 0, 0, 1);
    step("R10 unimpl write", 0, 8'hC1, 8'hFF, 1, 0, 0, 1);
    step("R10 unimpl read", 0, 8'hC1, 8'h00, 0, 0, 0, 1);
    step("R10 ram c1 intact", 1, 8'hC1, 8'h00, 0, 0, 0, 1);
    // register banks
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++)
        step("R4 reg write", 2, 8'(n), 8'(8'hB0 + b * 8 + n), 1, 0, 2'(b), 1);
    step("R4 bank2 r5 direct", 0, 8'h15, 8'h00, 0, 0, 0, 1);
    step("R4 bank3 r7 read", 2, 8'hF7, 8'h00, 0, 0, 2'd3, 1);
    step("R4 bank1 r0 read", 2, 8'h00, 8'h00, 0, 0, 2'd1, 1);
    // stack
    step("R5 first push", 4, 8'h00, 8'h11, 0, 0, 0, 1);
    step("R5 lands at 08", 0, 8'h08, 8'h00, 0, 0, 0, 1);
    step("R5 sp now 08", 0, 8'h81, 8'h00, 0, 0, 0, 1);
    step("R6 pop", 5, 8'h00, 8'h00, 0, 0, 0, 1);
    step("R6 sp back 07", 0, 8'h81, 8'h00, 0, 0, 0, 1);
    step("R11 sp write", 0, 8'h81, 8'hFF, 1, 0, 0, 1);
    step("R6 push wraps", 4, 8'h00, 8'h22, 0, 0, 0, 1);
    step("R6 wrapped at 00", 0, 8'h00, 8'h00, 0, 0, 0, 1);
    step("R6 pop wrap", 5, 8'h00, 8'h00, 0, 0, 0, 1);
    step("R6 pop upper", 5, 8'h00, 8'h00, 0, 0, 0, 1);
    step("R6 sp fe", 0, 8'h81, 8'h00, 0, 0, 0, 1);
    step("R11 sp write 7f", 0, 8'h81, 8'h7F, 1, 0, 0, 1);
    step("R6 push to upper", 4, 8'h00, 8'h66, 0, 0, 0, 1);
    step("R6 upper via indirect", 1, 8'h80, 8'h00, 0, 0, 0, 1);
    // bit region
    step("R7 byte preset", 0, 8'h22, 8'hA5, 1, 0, 0, 1);
    step("R7 bit read", 3, 8'h12, 8'h00, 0, 0, 0, 1);
    step("R8 bit set", 3, 8'h13, 8'h00, 1, 1, 0, 1);
    step("R8 others kept", 0, 8'h22, 8'h00, 0, 0, 0, 1);
    step("R8 bit clear", 3, 8'h7F, 8'h00, 1, 0, 0, 1);
    step("R7 byte 2f", 1, 8'h2F, 8'h00, 0, 0, 0, 1);
    step("R7 bit 00", 3, 8'h00, 8'h00, 1, 1, 0, 1);
    step("R7 byte 20", 0, 8'h20, 8'h00, 0, 0, 0, 1);
    // SFR bits
    step("R9 sfr bit set", 3, 8'h93, 8'h00, 1, 1, 0, 1);
    step("R9 sfr byte", 0, 8'h90, 8'h00, 0, 0, 0, 1);
    step("R9 sfr bit clear", 3, 8'hF6, 8'h00, 1, 0, 0, 1);
    step("R9 sfr byte f0", 0, 8'hF0, 8'h00, 0, 0, 0, 1);
    step("R10 unimpl bit", 3, 8'hC5, 8'h00, 1, 1, 0, 1);
    step("R10 unimpl bit read", 3, 8'hC5, 8'h00, 0, 0, 0, 1);
    // holding
    step("R12 kind 6", 6, 8'h22, 8'h00, 1, 0, 0, 1);
    step("R12 kind 7", 7, 8'h22, 8'h00, 1, 0, 0, 1);
    idle("R12 idle");
    step("R12 after kinds", 0, 8'h22, 8'h00, 0, 0, 0, 1);
    step("R12 stale valid low", 0, 8'h90, 8'h00, 1, 0, 0, 0);
    step("R12 90 unchanged", 0, 8'h90, 8'h00, 0, 0, 0, 1);
    idle("R12 end");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule